// File: doc/BRIEF.md
# Triangular Down-Spread Modulation Profile Generator

This block produces the frequency-offset word that a fractional divider in a clock path adds to its nominal ratio in order to spread the output spectrum. The word follows a symmetric triangle. It starts at zero, falls linearly to the deepest negative deviation over one half of the modulation period, and rises linearly back to zero over the other half. The offset is never positive, so the synthesized frequency never exceeds nominal. The deepest point is 0.5% of the nominal divider value. One word drives all outputs of the clock generator, so every output receives the same offset at the same time.

The block runs on a fixed reference clock. Each clock edge is one profile tick. The period in ticks is the reference rate divided by the modulation rate, which is about 3174 ticks for a 100 MHz tick and a 31.5 kHz profile. The ramp uses an error accumulator, so the offset moves by at most one LSB per tick and lands exactly on the full depth at mid-period. An external spread-enable pin is synchronised. The block acts on that pin only at the zero-offset point of the profile: a profile that has started always completes its period, and a new period starts only from rest. A phase code reports whether the profile is idle, falling or rising.

Top module: `ssc_tri_profile`

## Requirements
- R1: While rst_ni is low, offset_o is 0 and phase_o is 0 (idle), with no clock edge needed.
- R2: offset_o, read as two's complement, always stays within -OFFSET_MAX to 0. OFFSET_MAX is NOM_DIV/200.
- R3: j ticks after the profile enters the falling phase (0 <= j < H), offset_o equals -floor(j*OFFSET_MAX/H). Successive ticks differ by at most one LSB. H is floor(floor(TICK_HZ/MOD_HZ)/2).
- R4: Exactly H ticks after the falling phase begins, offset_o equals -OFFSET_MAX and phase_o is 2.
- R5: In the rising phase, j ticks after it begins, offset_o equals -(OFFSET_MAX - floor(j*OFFSET_MAX/H)). The offset is 0 at 2H ticks after the period started.
- R6: spread_en_i passes a SYNC_STAGES flop synchroniser; the default is 2. When idle, a high level that is set up before rising edge e0 leaves phase_o at 0 after edge e0+1 and gives phase 1 after edge e0+2. A pulse lasting a single cycle is enough to start a full period.
- R7: Driving spread_en_i low during a period does not shorten that period. The profile finishes its rise to zero and then goes idle.
- R8: While idle with spread_en_i low, offset_o stays 0 and phase_o stays 0.
- R9: With spread_en_i held high, periods follow back to back. At 2H ticks the phase is 1 again with offset 0.
- R10: The phase_o codes are 0 for idle, 1 for falling and 2 for rising. Code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spread_en_i | input | 1 | Asynchronous spread request |
| offset_o | output | OFS_W | Signed frequency-offset word (zero or negative) |
| phase_o | output | 2 | Profile phase code |

## Verification
The offset and phase come from registers and reach the ports with no further latency. The bench samples them on the falling edge after each tick: j falling-edge samples after the phase first reads 1, the offset must match the R3 or R5 formula for position j. A request set on a falling edge crosses two synchroniser flops and the state register. The bench therefore checks for phase 0 after two rising edges and for phase 1 after the third, and counts ramp positions from there. Reset is asynchronous, so it is checked one time unit after rst_ni falls, before any edge.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DOWN = 2'd1,
    PH_UP   = 2'd2
  } ssc_phase_e;
endpackage

// File: rtl/ssc_en_sync.sv
module ssc_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/ssc_step_gen.sv
// Error accumulator: DEPTH unit steps spread evenly over HALF ticks.
module ssc_step_gen #(
  parameter int HALF  = 1587,
  parameter int DEPTH = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic step_o,
  output logic half_end_o
);
  localparam int CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
  localparam int ACC_W = $clog2(HALF + DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);
  localparam logic [ACC_W-1:0] HALF_A   = ACC_W'(HALF);
  localparam logic [ACC_W-1:0] DEPTH_A  = ACC_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  assign acc_sum    = acc_q + DEPTH_A;
  assign step_o     = run_i && (acc_sum >= HALF_A);
  assign half_end_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (half_end_o) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= step_o ? (acc_sum - HALF_A) : acc_sum;
    end
  end

  a_r3_acc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < HALF_A);
  a_r3_cnt_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/ssc_tri_ctrl.sv
module ssc_tri_ctrl
  import ssc_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int MAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             half_end_i,
  output ssc_phase_e       phase_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             run_o
);
  localparam logic [MAG_W-1:0] DEPTH_M = MAG_W'(DEPTH);

  ssc_phase_e       ph_q, ph_d;
  logic [MAG_W-1:0] mag_q, mag_d;

  always_comb begin
    ph_d  = ph_q;
    mag_d = mag_q;
    unique case (ph_q)
      PH_IDLE: begin
        mag_d = '0;
        if (en_i) ph_d = PH_DOWN;
      end
      PH_DOWN: begin
        if (step_i)     mag_d = mag_q + 1'b1;
        if (half_end_i) ph_d  = PH_UP;
      end
      PH_UP: begin
        if (step_i)     mag_d = mag_q - 1'b1;
        if (half_end_i) ph_d  = en_i ? PH_DOWN : PH_IDLE;
      end
      default: begin
        ph_d  = PH_IDLE;
        mag_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      mag_q <= '0;
    end else begin
      ph_q  <= ph_d;
      mag_q <= mag_d;
    end
  end

  assign phase_o = ph_q;
  assign mag_o   = mag_q;
  assign run_o   = (ph_q != PH_IDLE);

  a_r2_mag_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_q <= DEPTH_M);
  a_r3_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_q == $past(mag_q)) || (mag_q == $past(mag_q) + 1'b1) ||
    (mag_q + 1'b1 == $past(mag_q)));
  a_r4_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DOWN && half_end_i) |=> (mag_q == DEPTH_M && ph_q == PH_UP));
  a_r5_back_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_UP && half_end_i) |=> (mag_q == '0));
  a_r7_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DOWN) |=> (ph_q != PH_IDLE));
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE) |-> (mag_q == '0));
  a_r10_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != 2'd3);
endmodule

// File: rtl/ssc_tri_profile.sv
module ssc_tri_profile
  import ssc_pkg::*;
#(
  parameter int OFS_W       = 16,
  parameter int NOM_DIV     = 4000,
  parameter int TICK_HZ     = 100_000_000,
  parameter int MOD_HZ      = 31_500,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spread_en_i,
  output logic [OFS_W-1:0] offset_o,
  output logic [1:0]       phase_o
);
  localparam int PERIOD     = TICK_HZ / MOD_HZ;
  localparam int HALF       = PERIOD / 2;
  localparam int OFFSET_MAX = NOM_DIV / 200;
  localparam int MAG_W      = $clog2(OFFSET_MAX + 1);

  logic             en_s;
  logic             run, step, half_end;
  logic [MAG_W-1:0] mag;
  ssc_phase_e       phase;

  ssc_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (spread_en_i),
    .q_o   (en_s)
  );

  ssc_step_gen #(.HALF(HALF), .DEPTH(OFFSET_MAX)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .step_o    (step),
    .half_end_o(half_end)
  );

  ssc_tri_ctrl #(.DEPTH(OFFSET_MAX), .MAG_W(MAG_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_s),
    .step_i    (step),
    .half_end_i(half_end),
    .phase_o   (phase),
    .mag_o     (mag),
    .run_o     (run)
  );

  assign offset_o = OFS_W'(0) - {{(OFS_W-MAG_W){1'b0}}, mag};
  assign phase_o  = phase;

  a_r2_down_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(offset_o) <= 0) && ($signed(offset_o) >= -OFFSET_MAX));
  a_r1_idle_flat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |-> (offset_o == '0));
endmodule

// File: tb/ssc_tri_profile_tb.sv
module ssc_tri_profile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 16;
  localparam int NOM   = 1000;
  localparam int TICK  = 2400;
  localparam int MODF  = 100;
  localparam int H     = (TICK / MODF) / 2;
  localparam int D     = NOM / 200;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en = 1'b0;
  logic [OFS_W-1:0] offset;
  logic [1:0]       phase;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssc_tri_profile #(
    .OFS_W(OFS_W), .NOM_DIV(NOM), .TICK_HZ(TICK), .MOD_HZ(MODF), .SYNC_STAGES(2)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .spread_en_i(en),
    .offset_o(offset), .phase_o(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ofs();
    return int'($signed(offset));
  endfunction

  // from a negedge after setting en: two edges idle, third edge falling
  task automatic wait_start(input string req);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(req, phase, 0);
    @(negedge clk);
    chk(req, phase, 1);
  endtask

  task automatic run_ramp(input int j0, input int n);
    for (int j = j0; j < j0 + n; j++) begin
      int k = j % (2 * H);
      int em, ep;
      if (k < H) begin em = (k * D) / H;           ep = 1; end
      else       begin em = D - ((k - H) * D) / H; ep = 2; end
      if (k == H)             begin chk("R4", ofs(), -D);  chk("R4", phase, 2); end
      else if (k == 0 && j>0) begin chk("R9", ofs(), 0);   chk("R9", phase, 1); end
      else if (k < H)         begin chk("R3", ofs(), -em); chk("R10", phase, ep); end
      else                    begin chk("R5", ofs(), -em); chk("R10", phase, ep); end
      chk("R2", int'(ofs() <= 0 && ofs() >= -D), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1", ofs(), 0);
    chk("R1", phase, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8", ofs(), 0);
      chk("R8", phase, 0);
    end
  endtask

  task automatic t_single();
    en = 1'b1;
    wait_start("R6");
    run_ramp(0, 3);
    en = 1'b0;   // R7: drop mid-fall
    run_ramp(3, 2 * H - 3);
    chk("R7", phase, 0);
    chk("R7", ofs(), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8", phase, 0);
      chk("R8", ofs(), 0);
    end
  endtask

  task automatic t_continuous();
    en = 1'b1;
    wait_start("R6");
    run_ramp(0, 4 * H + 1);
    en = 1'b0;
    run_ramp(4 * H + 1, 2 * H - 1);
    chk("R7", phase, 0);
    chk("R7", ofs(), 0);
  endtask

  task automatic t_pulse();
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6", phase, 0);
    @(negedge clk);
    chk("R6", phase, 1);
    run_ramp(0, 2 * H);
    chk("R6", phase, 0);
  endtask

  task automatic t_reset_mid();
    en = 1'b1;
    wait_start("R6");
    run_ramp(0, H + 2);
    rst_ni = 1'b0;
    #1;
    chk("R1", ofs(), 0);
    chk("R1", phase, 0);
    en = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", phase, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_continuous();
    t_pulse();
    t_reset_mid();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule